// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

An eight-pin general-purpose I/O port controlled through a simple register bus. Each pin has its own direction, output level, pull-resistor enable and two-bit function selector. It can be driven by the port's own output register or handed over to one of two peripheral sources. Pin levels come in through a two-flop synchronizer and can be read back at any time. The synchronized levels also go to the peripherals.

Each pin also has an interrupt enable, an edge polarity bit and a sticky event flag. A flag is raised when the synchronized pin level makes the selected transition. Software can set or clear flags by writing the flag register. Every pin whose flag and enable are both set drives one shared interrupt line. Pins handed to a peripheral never contribute to that line.

The register bus is write-strobed and reads are combinational from the address. Registers sit at word offsets 0 to 8: level (0, read-only), drive (1), direction (2), pull enable (3), function high bit (4), function low bit (5), interrupt enable (6), edge polarity (7) and flag (8). Any other offset reads as zero.

Top module: `gpio_edge_port`

## Requirements
- R1: A direction bit of 1 makes `pin_oe` high for that pin, and 0 makes it low, whatever function the pin has selected. A write to offset 2 appears on `pin_oe` one cycle after the write edge.
- R2: Reading offset 0 returns each pin's level after two synchronizer flops. A change on `pin_in` is readable after the second rising edge. Writes to offset 0 change no register and no output.
- R3: Offset 1 reads back the last value written to it. A pin in GPIO function drives that bit on `pin_out`.
- R4: `pad_pull_en` follows the pull enable register at offset 3. `pad_pull_up` carries the drive register bit: 1 requests a pull-up and 0 a pull-down.
- R5: The function pair for each pin is {bit of offset 4, bit of offset 5}. 00 drives the drive register bit. 01 drives `prim_out`. 10 is reserved and drives 0. 11 drives `sec_out`.
- R6: An edge polarity bit (offset 7) of 0 raises the flag on a low-to-high transition of the synchronized level. A bit of 1 raises it on a high-to-low transition. The flag is visible on the third rising edge after the pin changes.
- R7: Writing offset 8 loads the flags, so a 1 sets and a 0 clears. Hardware never clears a flag.
- R8: If a detected edge and a software write of 0 to its flag happen on the same cycle, the flag ends up set.
- R9: A pin whose function pair is non-zero raises no flag from edges and does not contribute to `irq`.
- R10: `irq` is high exactly when some GPIO pin has both its flag and its enable (offset 6) set.
- R11: A write to offset 1 or 2 that changes the level seen on a looped-back output pin raises that pin's flag when the change matches its edge polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |
| pad_pull_en | output | 8 | Pull resistor enable per pin |
| pad_pull_up | output | 8 | Pull direction per pin, 1 up, 0 down |
| prim_out | input | 8 | Primary peripheral output values |
| sec_out | input | 8 | Secondary peripheral output values |
| periph_in | output | 8 | Synchronized pin levels for peripherals |
| irq | output | 1 | Combined pin interrupt |

## Verification
Register writes show on the outputs and in read data one cycle after the write edge. A pin level change is readable after two rising edges. Its flag and `irq` follow on the third edge. A write that alters a looped-back output level raises a flag three edges after that write. The bench models the pads with a loopback: a driven pin reads its own output. It waits at least the due number of edges before queuing an expected value, and the monitor samples one nanosecond after the next rising edge, when the value is steady. The same-cycle clear case is timed exactly: the write of 0 lands on the edge at which the flag is raised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_LEVEL = 4'd0,
    RA_DRIVE = 4'd1,
    RA_DIR   = 4'd2,
    RA_PULL  = 4'd3,
    RA_FHI   = 4'd4,
    RA_FLO   = 4'd5,
    RA_IRQEN = 4'd6,
    RA_EDGE  = 4'd7,
    RA_FLAG  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_PRIM = 2'b01,
    FN_RSVD = 2'b10,
    FN_SEC  = 2'b11
  } pin_fn_e;

  // Edge match on one pin: falling selects high-to-low, else low-to-high.
  function automatic logic edge_hit(logic now_lvl, logic old_lvl, logic falling);
    return falling ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
  endfunction

  // Output source for one pin given its function pair.
  function automatic logic pick_out(pin_fn_e fn, logic gpio_v, logic prim_v, logic sec_v);
    logic r;
    case (fn)
      FN_GPIO: r = gpio_v;
      FN_PRIM: r = prim_v;
      FN_SEC:  r = sec_v;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] chain [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_q = chain[STAGES-1];
  assign prev_q = chain[STAGES];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] fn_hi,
  input  logic [WIDTH-1:0] fn_lo,
  input  logic [WIDTH-1:0] drive,
  input  logic [WIDTH-1:0] prim_out,
  input  logic [WIDTH-1:0] sec_out,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] gpio_mask
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_fn_e fn;
    assign fn           = pin_fn_e'({fn_hi[i], fn_lo[i]});
    assign pin_out[i]   = pick_out(fn, drive[i], prim_out[i], sec_out[i]);
    assign gpio_mask[i] = (fn == FN_GPIO);
  end

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_lvl,
  input  logic [WIDTH-1:0] prev_lvl,
  input  logic [WIDTH-1:0] edge_fall,
  input  logic [WIDTH-1:0] gpio_mask,
  input  logic             sw_wr,
  input  logic [WIDTH-1:0] sw_data,
  output logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] flags
);

  logic [WIDTH-1:0] flags_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    assign hw_set[i] = gpio_mask[i] & edge_hit(sync_lvl[i], prev_lvl[i], edge_fall[i]);
  end

  // Hardware events are ORed after the software load so none is lost.
  assign flags_d = (sw_wr ? sw_data : flags) | hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((flags & $past(flags)) == $past(flags))); // R7

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R8

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pad_pull_en,
  output logic [WIDTH-1:0]  pad_pull_up,
  input  logic [WIDTH-1:0]  prim_out,
  input  logic [WIDTH-1:0]  sec_out,
  output logic [WIDTH-1:0]  periph_in,
  output logic              irq
);

  logic [WIDTH-1:0] drive_q, dir_q, pull_q, fhi_q, flo_q, ien_q, edge_q;
  logic [WIDTH-1:0] sync_lvl, prev_lvl, gpio_mask, flags, hw_set;
  logic             flag_wr;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
      fhi_q   <= '0;
      flo_q   <= '0;
      ien_q   <= '0;
      edge_q  <= '0;
    end else if (bus_we) begin
      case (reg_addr_e'(bus_addr))
        RA_DRIVE: drive_q <= bus_wdata;
        RA_DIR:   dir_q   <= bus_wdata;
        RA_PULL:  pull_q  <= bus_wdata;
        RA_FHI:   fhi_q   <= bus_wdata;
        RA_FLO:   flo_q   <= bus_wdata;
        RA_IRQEN: ien_q   <= bus_wdata;
        RA_EDGE:  edge_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign flag_wr = bus_we && (reg_addr_e'(bus_addr) == RA_FLAG);

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_q   (sync_lvl),
    .prev_q   (prev_lvl)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .fn_hi     (fhi_q),
    .fn_lo     (flo_q),
    .drive     (drive_q),
    .prim_out  (prim_out),
    .sec_out   (sec_out),
    .pin_out   (pin_out),
    .gpio_mask (gpio_mask)
  );

  gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_lvl  (sync_lvl),
    .prev_lvl  (prev_lvl),
    .edge_fall (edge_q),
    .gpio_mask (gpio_mask),
    .sw_wr     (flag_wr),
    .sw_data   (bus_wdata),
    .hw_set    (hw_set),
    .flags     (flags)
  );

  assign pin_oe      = dir_q;
  assign pad_pull_en = pull_q;
  assign pad_pull_up = drive_q;
  assign periph_in   = sync_lvl;
  assign irq         = |(flags & ien_q & gpio_mask);

  // Read mux
  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_LEVEL: bus_rdata = sync_lvl;
      RA_DRIVE: bus_rdata = drive_q;
      RA_DIR:   bus_rdata = dir_q;
      RA_PULL:  bus_rdata = pull_q;
      RA_FHI:   bus_rdata = fhi_q;
      RA_FLO:   bus_rdata = flo_q;
      RA_IRQEN: bus_rdata = ien_q;
      RA_EDGE:  bus_rdata = edge_q;
      RA_FLAG:  bus_rdata = flags;
      default:  bus_rdata = '0;
    endcase
  end

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_DIR) |=> (pin_oe == $past(bus_wdata))); // R1

  AST_LEVEL_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_LEVEL) |=> ($stable(pin_oe) && $stable(pad_pull_en) && $stable(pad_pull_up))); // R2

  AST_PERIPH_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (&(fhi_q | flo_q)) |-> !irq); // R9

endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in, pin_oe, pin_out, pull_en, pull_up, periph_in;
  logic [W-1:0] prim_out = '0, sec_out = '0;
  logic [W-1:0] ext = '0;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int         kind;   // 0 rdata, 1 oe, 2 pin_out, 3 irq, 4 pull_en, 5 pull_up
    logic [7:0] exp;
    int         req;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  // Pad model: a driven pin reads back its own output.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pad_pull_en(pull_en),
    .pad_pull_up(pull_up), .prim_out(prim_out), .sec_out(sec_out),
    .periph_in(periph_in), .irq(irq)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ext(input logic [7:0] v);
    @(negedge clk);
    ext = v;
    idle(4);
  endtask

  // Driver: queue an expected item; monitor samples after the next edge.
  task automatic expect_item(input int kind, input logic [3:0] a, input logic [7:0] e, input int req);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = kind; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor
  always begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = pin_oe;
        2: act = pin_out;
        3: act = {7'b0, irq};
        4: act = pull_en;
        default: act = pull_up;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL R%0d kind %0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // Reset state: R7 flags clear, R1 no drive, R10 no interrupt
    expect_item(0, 4'd8, 8'h00, 7);
    expect_item(1, 4'd0, 8'h00, 1);
    expect_item(3, 4'd0, 8'h00, 10);

    // R2 level readback, R6 rising edges raise flags, R10 no enable no irq
    set_ext(8'hA5);
    expect_item(0, 4'd0, 8'hA5, 2);
    expect_item(0, 4'd8, 8'hA5, 6);
    expect_item(3, 4'd0, 8'h00, 10);

    // R2 write to level register ignored
    wr(4'd0, 8'h00);
    expect_item(0, 4'd0, 8'hA5, 2);

    // R7 software clear
    wr(4'd8, 8'h00);
    expect_item(0, 4'd8, 8'h00, 7);

    // R3 drive register readback and GPIO output
    wr(4'd1, 8'h3C);
    expect_item(0, 4'd1, 8'h3C, 3);
    expect_item(2, 4'd0, 8'h3C, 3);

    // R1 direction, R11 loopback: pin3 rises (0->1), pin0 falls (ignored)
    wr(4'd2, 8'h0F);
    expect_item(1, 4'd0, 8'h0F, 1);
    idle(4);
    expect_item(0, 4'd8, 8'h08, 11);

    // R4 pulls
    wr(4'd3, 8'hF0);
    expect_item(4, 4'd0, 8'hF0, 4);
    expect_item(5, 4'd0, 8'h3C, 4);

    // R6 falling selection on all pins; upper nibble A->5: falls on 5 and 7
    wr(4'd7, 8'hFF);
    wr(4'd8, 8'h00);
    set_ext(8'h55);
    expect_item(0, 4'd8, 8'hA0, 6);

    // R10 enable gating
    wr(4'd6, 8'h20);
    expect_item(3, 4'd0, 8'h01, 10);
    wr(4'd6, 8'h01);
    expect_item(3, 4'd0, 8'h00, 10);

    // R8 edge and software clear on the same edge
    wr(4'd6, 8'h10);
    wr(4'd8, 8'h00);
    @(negedge clk);
    ext = 8'h45;              // pin4 falls
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 8'h00;
    @(negedge clk);
    bus_we = 1'b0;
    expect_item(0, 4'd8, 8'h10, 8);
    expect_item(3, 4'd0, 8'h01, 8);

    // R5 function selection: pin7 secondary, pin6 primary, pin5 reserved
    wr(4'd8, 8'h00);
    prim_out = 8'hC3;
    sec_out  = 8'h5A;
    wr(4'd4, 8'hA0);
    wr(4'd5, 8'hC0);
    expect_item(2, 4'd0, 8'h5C, 5);
    expect_item(1, 4'd0, 8'h0F, 1);

    // R9 peripheral pin: edge ignored, software flag gives no irq
    wr(4'd6, 8'h40);
    set_ext(8'h05);           // pin6 falls
    expect_item(0, 4'd8, 8'h00, 9);
    wr(4'd8, 8'h40);
    expect_item(0, 4'd8, 8'h40, 7);
    expect_item(3, 4'd0, 8'h00, 9);

    idle(3);
    done = 1;
    summary();
    $finish;
  end

endmodule